// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block watches the write strobes of a word-wide non-volatile memory and recognises short unlock command sequences in them. With those sequences it turns software write protection on and off, starts a self-timed whole-array erase, and moves into and out of an identification read mode. It feeds a page write controller with a single level, `wr_permit`, which says whether the words now being written may be taken into the page buffer. It also supplies an identification word that the read path returns instead of array data while `id_mode` is high.

Every command starts with two unlock words: key byte AA at address 5555h, then key byte 55 at address 2AAAh. A third word at 5555h carries the command byte. A0 arms a protected page load and also turns protection on. F0 leaves identification mode. 80 opens an extended prefix, which needs a second pair of unlock words and then a final command byte at 5555h: 10 erases the array, 20 disables protection and 60 enters identification mode. All keys, command bytes, unlock addresses and identification codes are parameters.

The sequencer has six states. `SQ_IDLE` goes to `SQ_A1` on the first key. `SQ_A1` goes to `SQ_A2` on the second key. From `SQ_A2`, byte 80 at 5555h leads to `SQ_EXT`. `SQ_EXT` goes to `SQ_B1` on the first key, and `SQ_B1` goes to `SQ_B2` on the second key. Every other write, and every final command word, returns the machine to `SQ_IDLE`. A final command is acted on in the cycle after its strobe.

Top module: `wpseq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `prot_on`=1, `id_mode`=0, `erase_busy`=0 and `wr_permit`=0. Reset therefore restores protection rather than clearing it.
- R2: While protection is on and no page load is armed, `wr_permit` is 0.
- R3: The sequence AA@5555h, 55@2AAAh, A0@5555h sets `prot_on` and arms the page load, so `wr_permit`=1 from the next cycle. It stays 1 over data writes until a cycle with `load_end`=1, and is 0 in the cycle after that one.
- R4: While protection is off and no erase runs, `wr_permit` is 1.
- R5: The six-word sequence AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh, 20@5555h clears `prot_on` from the next cycle. Only that sequence clears it.
- R6: The same six-word structure ending in 10 raises `erase_busy` in the next cycle for exactly ERASE_CYCLES cycles. While it is high, `wr_permit` is 0 and all strobes are ignored.
- R7: The six-word structure ending in 60 sets `id_mode`. The three-word sequence ending in F0 clears it.
- R8: `id_word` is MFR_CODE (default 16'h00DA) for `rd_addr`=0, DEV_CODE (default 16'h004F) for `rd_addr`=1, and 0 for any other address.
- R9: A strobe that does not match the next expected word returns the sequencer to idle with no effect. A following command word is then ignored until a fresh unlock is written.
- R10: Only data bits 7:0 are compared with keys and command bytes. Bits 15:8 are ignored.
- R11: If `load_end` arrives in the same cycle as the A0 command word, arming wins and `wr_permit` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle decoded write strobe |
| wr_addr | input | 16 | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| load_end | input | 1 | Page load window closed (from the page write controller) |
| rd_addr | input | 16 | Read address used to select the identification word |
| prot_on | output | 1 | Software write protection active |
| wr_permit | output | 1 | Writes may enter the page buffer |
| erase_busy | output | 1 | Timed whole-array erase in progress |
| id_mode | output | 1 | Reads must return `id_word` |
| id_word | output | 16 | Identification word for `rd_addr` |

## Verification
Two events can land in the same cycle: the page controller closing a load window with `load_end`, and the A0 command word that arms the next load. The bench drives both in one cycle and expects `wr_permit` to be 1 afterwards. The erase timer's last busy cycle can also meet incoming strobes. To cover that, a full unlock-and-arm sequence is written while the erase runs, and the bench expects `wr_permit` to still be 0 once the erase ends, with the measured busy window exactly ERASE_CYCLES long.

// File: rtl/wpseq_pkg.sv
package wpseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_A1   = 3'd1,
        SQ_A2   = 3'd2,
        SQ_EXT  = 3'd3,
        SQ_B1   = 3'd4,
        SQ_B2   = 3'd5
    } seq_st_e;

    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_PROG  = 3'd1,
        ACT_IDX   = 3'd2,
        ACT_DIS   = 3'd3,
        ACT_ERASE = 3'd4,
        ACT_IDN   = 3'd5
    } cmd_act_e;

endpackage

// File: rtl/wpseq_fsm.sv
module wpseq_fsm
    import wpseq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] ADR_UNLK1 = 16'h5555,
    parameter logic [15:0] ADR_UNLK2 = 16'h2AAA,
    parameter logic [7:0]  KEY1      = 8'hAA,
    parameter logic [7:0]  KEY2      = 8'h55,
    parameter logic [7:0]  CMD_PROG  = 8'hA0,
    parameter logic [7:0]  CMD_EXT   = 8'h80,
    parameter logic [7:0]  CMD_ERASE = 8'h10,
    parameter logic [7:0]  CMD_DIS   = 8'h20,
    parameter logic [7:0]  CMD_IDN   = 8'h60,
    parameter logic [7:0]  CMD_IDX   = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        cbyte,
    output seq_st_e           st,
    output cmd_act_e          act
);

    seq_st_e st_q, st_d;
    logic    at_a1, at_a2, key1_hit, key2_hit;

    assign at_a1    = (addr == ADDR_W'(ADR_UNLK1));
    assign at_a2    = (addr == ADDR_W'(ADR_UNLK2));
    assign key1_hit = at_a1 && (cbyte == KEY1);
    assign key2_hit = at_a2 && (cbyte == KEY2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (stb) begin
            unique case (st_q)
                SQ_IDLE: st_d = key1_hit ? SQ_A1 : SQ_IDLE;
                SQ_A1:   st_d = key2_hit ? SQ_A2 : SQ_IDLE;
                SQ_A2:   st_d = (at_a1 && cbyte == CMD_EXT) ? SQ_EXT : SQ_IDLE;
                SQ_EXT:  st_d = key1_hit ? SQ_B1 : SQ_IDLE;
                SQ_B1:   st_d = key2_hit ? SQ_B2 : SQ_IDLE;
                SQ_B2:   st_d = SQ_IDLE;
                default: st_d = SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        act = ACT_NONE;
        if (stb && at_a1) begin
            unique case (st_q)
                SQ_A2: begin
                    if (cbyte == CMD_PROG)     act = ACT_PROG;
                    else if (cbyte == CMD_IDX) act = ACT_IDX;
                end
                SQ_B2: begin
                    if (cbyte == CMD_ERASE)    act = ACT_ERASE;
                    else if (cbyte == CMD_DIS) act = ACT_DIS;
                    else if (cbyte == CMD_IDN) act = ACT_IDN;
                end
                default: act = ACT_NONE;
            endcase
        end
    end

    assign st = st_q;

endmodule

// File: rtl/wpseq_mode_regs.sv
module wpseq_mode_regs
    import wpseq_pkg::*;
#(
    parameter bit PROT_INIT = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_act_e act,
    input  logic     load_end,
    output logic     prot_q,
    output logic     arm_q,
    output logic     id_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= PROT_INIT;
            arm_q  <= 1'b0;
            id_q   <= 1'b0;
        end else begin
            unique case (act)
                ACT_PROG: begin
                    prot_q <= 1'b1;
                    arm_q  <= 1'b1;
                end
                ACT_DIS: begin
                    prot_q <= 1'b0;
                    arm_q  <= 1'b0;
                end
                ACT_ERASE: arm_q <= 1'b0;
                ACT_IDN:   id_q  <= 1'b1;
                ACT_IDX:   id_q  <= 1'b0;
                ACT_NONE:  if (load_end) arm_q <= 1'b0;
                default:   arm_q <= arm_q;
            endcase
        end
    end

endmodule

// File: rtl/wpseq_erase_tmr.sv
module wpseq_erase_tmr #(
    parameter int ERASE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == '0) busy  <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(ERASE_CYCLES - 1);
        end
    end

endmodule

// File: rtl/wpseq_top.sv
module wpseq_top
    import wpseq_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          DATA_W       = 16,
    parameter logic [15:0] ADR_UNLK1    = 16'h5555,
    parameter logic [15:0] ADR_UNLK2    = 16'h2AAA,
    parameter logic [7:0]  KEY1         = 8'hAA,
    parameter logic [7:0]  KEY2         = 8'h55,
    parameter logic [7:0]  CMD_PROG     = 8'hA0,
    parameter logic [7:0]  CMD_EXT      = 8'h80,
    parameter logic [7:0]  CMD_ERASE    = 8'h10,
    parameter logic [7:0]  CMD_DIS      = 8'h20,
    parameter logic [7:0]  CMD_IDN      = 8'h60,
    parameter logic [7:0]  CMD_IDX      = 8'hF0,
    parameter logic [15:0] MFR_CODE     = 16'h00DA,
    parameter logic [15:0] DEV_CODE     = 16'h004F,
    parameter int          ERASE_CYCLES = 1000,
    parameter bit          PROT_INIT    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_end,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prot_on,
    output logic              wr_permit,
    output logic              erase_busy,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_word
);

    seq_st_e  seq_st;
    cmd_act_e seq_act;
    logic     stb_ok, arm_q, unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:8];
    assign stb_ok    = wr_stb && !erase_busy;

    wpseq_fsm #(
        .ADDR_W(ADDR_W), .ADR_UNLK1(ADR_UNLK1), .ADR_UNLK2(ADR_UNLK2),
        .KEY1(KEY1), .KEY2(KEY2), .CMD_PROG(CMD_PROG), .CMD_EXT(CMD_EXT),
        .CMD_ERASE(CMD_ERASE), .CMD_DIS(CMD_DIS), .CMD_IDN(CMD_IDN),
        .CMD_IDX(CMD_IDX)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .stb(stb_ok), .addr(wr_addr),
        .cbyte(wr_data[7:0]), .st(seq_st), .act(seq_act)
    );

    wpseq_mode_regs #(.PROT_INIT(PROT_INIT)) regs_i (
        .clk(clk), .rst_n(rst_n), .act(seq_act), .load_end(load_end),
        .prot_q(prot_on), .arm_q(arm_q), .id_q(id_mode)
    );

    wpseq_erase_tmr #(.ERASE_CYCLES(ERASE_CYCLES)) tmr_i (
        .clk(clk), .rst_n(rst_n), .start(seq_act == ACT_ERASE),
        .busy(erase_busy)
    );

    always_comb begin
        wr_permit = !erase_busy && (!prot_on || arm_q);
        if (rd_addr == ADDR_W'(0))      id_word = DATA_W'(MFR_CODE);
        else if (rd_addr == ADDR_W'(1)) id_word = DATA_W'(DEV_CODE);
        else                            id_word = '0;
    end

endmodule

// File: rtl/wpseq_chk.sv
module wpseq_chk
    import wpseq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] ADR_UNLK2 = 16'h2AAA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              load_end,
    input logic              prot_on,
    input logic              wr_permit,
    input logic              erase_busy,
    input logic              id_mode,
    input seq_st_e           seq_st,
    input cmd_act_e          seq_act
);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (prot_on && !id_mode && !erase_busy));

    p_arm_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_act == ACT_PROG && load_end) |=> wr_permit);

    p_prot_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(seq_act == ACT_DIS));

    p_erase_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_busy) |-> $past(seq_act == ACT_ERASE));

    p_erase_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |=> $stable(seq_st));

    p_id_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> $past(seq_act == ACT_IDN));

    p_break_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !erase_busy && seq_st == SQ_A1 && wr_addr != ADDR_W'(ADR_UNLK2))
        |=> seq_st == SQ_IDLE);

endmodule

bind wpseq_top wpseq_chk #(.ADDR_W(ADDR_W), .ADR_UNLK2(ADR_UNLK2)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .load_end(load_end), .prot_on(prot_on), .wr_permit(wr_permit),
    .erase_busy(erase_busy), .id_mode(id_mode), .seq_st(seq_st),
    .seq_act(seq_act)
);

// File: tb/wpseq_top_tb_top.sv
`timescale 1ns/1ps
module wpseq_top_tb_top;

    localparam int ERASE_N = 50;
    localparam int NV      = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        load_end = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        prot_on, wr_permit, erase_busy, id_mode;
    logic [15:0] id_word;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wpseq_top #(.ERASE_CYCLES(ERASE_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_end(load_end), .rd_addr(rd_addr),
        .prot_on(prot_on), .wr_permit(wr_permit), .erase_busy(erase_busy),
        .id_mode(id_mode), .id_word(id_word)
    );

    // fields: stb, load_end, addr, data, expected prot_on, wr_permit, id_mode
    localparam logic [36:0] VEC [NV] = '{
        {1'b1,1'b0,16'h5555,16'h00AA,1'b1,1'b0,1'b0}, // R2 locked during unlock
        {1'b1,1'b0,16'h2AAA,16'h0055,1'b1,1'b0,1'b0},
        {1'b1,1'b0,16'h5555,16'h00A0,1'b1,1'b1,1'b0}, // R3 armed
        {1'b1,1'b0,16'h0100,16'h1234,1'b1,1'b1,1'b0}, // R3 data word
        {1'b0,1'b1,16'h0000,16'h0000,1'b1,1'b0,1'b0}, // R3 load end
        {1'b1,1'b0,16'h5555,16'h00AA,1'b1,1'b0,1'b0},
        {1'b1,1'b0,16'h2AAA,16'h0055,1'b1,1'b0,1'b0},
        {1'b1,1'b0,16'h5555,16'h0080,1'b1,1'b0,1'b0},
        {1'b1,1'b0,16'h5555,16'h00AA,1'b1,1'b0,1'b0},
        {1'b1,1'b0,16'h2AAA,16'h0055,1'b1,1'b0,1'b0},
        {1'b1,1'b0,16'h5555,16'h0020,1'b0,1'b1,1'b0}, // R5 R4
        {1'b1,1'b0,16'h5555,16'h00AA,1'b0,1'b1,1'b0},
        {1'b1,1'b0,16'h2AAA,16'h0055,1'b0,1'b1,1'b0},
        {1'b1,1'b0,16'h5555,16'h0080,1'b0,1'b1,1'b0},
        {1'b1,1'b0,16'h5555,16'h00AA,1'b0,1'b1,1'b0},
        {1'b1,1'b0,16'h2AAA,16'h0055,1'b0,1'b1,1'b0},
        {1'b1,1'b0,16'h5555,16'h0060,1'b0,1'b1,1'b1}, // R7 entry
        {1'b1,1'b0,16'h5555,16'h00AA,1'b0,1'b1,1'b1},
        {1'b1,1'b0,16'h2AAA,16'h0055,1'b0,1'b1,1'b1},
        {1'b1,1'b0,16'h5555,16'h00F0,1'b0,1'b1,1'b0}, // R7 exit
        {1'b1,1'b0,16'h5555,16'h00AA,1'b0,1'b1,1'b0},
        {1'b1,1'b0,16'h1234,16'h0055,1'b0,1'b1,1'b0}, // R9 broken
        {1'b1,1'b0,16'h5555,16'h00A0,1'b0,1'b1,1'b0}, // R9 no effect
        {1'b1,1'b0,16'h5555,16'h00AA,1'b0,1'b1,1'b0},
        {1'b1,1'b0,16'h2AAA,16'h0055,1'b0,1'b1,1'b0},
        {1'b1,1'b0,16'h5555,16'h00A0,1'b1,1'b1,1'b0}, // R3 enable
        {1'b0,1'b1,16'h0000,16'h0000,1'b1,1'b0,1'b0}, // R2
        {1'b1,1'b0,16'h5555,16'h12AA,1'b1,1'b0,1'b0}, // R10 upper bits
        {1'b1,1'b0,16'h2AAA,16'hFF55,1'b1,1'b0,1'b0},
        {1'b1,1'b0,16'h5555,16'h77A0,1'b1,1'b1,1'b0}, // R10 armed
        {1'b0,1'b1,16'h0000,16'h0000,1'b1,1'b0,1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic stb, input logic [15:0] a, input logic [15:0] d, input logic le);
        @(negedge clk);
        wr_stb = stb; wr_addr = a; wr_data = d; load_end = le;
        @(negedge clk);
        wr_stb = 1'b0; load_end = 1'b0;
    endtask

    task automatic six(input logic [15:0] cmd);
        wr(1'b1, 16'h5555, 16'h00AA, 1'b0);
        wr(1'b1, 16'h2AAA, 16'h0055, 1'b0);
        wr(1'b1, 16'h5555, 16'h0080, 1'b0);
        wr(1'b1, 16'h5555, 16'h00AA, 1'b0);
        wr(1'b1, 16'h2AAA, 16'h0055, 1'b0);
        wr(1'b1, 16'h5555, cmd, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        logic bad_permit;
        repeat (3) @(negedge clk);
        check("R1 prot_on", 32'(prot_on), 32'd1);
        check("R1 erase_busy", 32'(erase_busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 id_mode", 32'(id_mode), 32'd0);
        check("R1 wr_permit", 32'(wr_permit), 32'd0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][36], VEC[i][34:19], VEC[i][18:3], VEC[i][35]);
            check($sformatf("R3/R5/R7/R9/R10 row %0d prot", i), 32'(prot_on), 32'(VEC[i][2]));
            check($sformatf("R2/R3/R4 row %0d permit", i), 32'(wr_permit), 32'(VEC[i][1]));
            check($sformatf("R7 row %0d id", i), 32'(id_mode), 32'(VEC[i][0]));
        end

        // R6: erase window length, strobes ignored while busy
        six(16'h0010);
        n = 0;
        bad_permit = 1'b0;
        while (erase_busy && n < 1000) begin
            n++;
            if (wr_permit) bad_permit = 1'b1;
            wr_stb = (n <= 3);
            wr_addr = (n == 2) ? 16'h2AAA : 16'h5555;
            wr_data = (n == 1) ? 16'h00AA : (n == 2) ? 16'h0055 : 16'h00A0;
            @(negedge clk);
        end
        wr_stb = 1'b0;
        check("R6 busy length", 32'(n), 32'(ERASE_N));
        check("R6 permit low while busy", 32'(bad_permit), 32'd0);
        @(negedge clk);
        check("R6 strobes ignored during erase", 32'(wr_permit), 32'd0);
        check("R6 protection kept", 32'(prot_on), 32'd1);

        // R11: load_end in the same cycle as the arming word
        wr(1'b1, 16'h5555, 16'h00AA, 1'b0);
        wr(1'b1, 16'h2AAA, 16'h0055, 1'b0);
        wr(1'b1, 16'h5555, 16'h00A0, 1'b1);
        check("R11 arm wins", 32'(wr_permit), 32'd1);
        wr(1'b0, 16'h0000, 16'h0000, 1'b1);
        check("R11 later load_end disarms", 32'(wr_permit), 32'd0);

        // R8: identification words
        rd_addr = 16'h0000; #1;
        check("R8 addr0", 32'(id_word), 32'h00DA);
        rd_addr = 16'h0001; #1;
        check("R8 addr1", 32'(id_word), 32'h004F);
        rd_addr = 16'h0002; #1;
        check("R8 other", 32'(id_word), 32'h0000);

        // R1: reset restores protection and clears identification mode
        six(16'h0020);
        check("R5 disabled", 32'(prot_on), 32'd0);
        six(16'h0060);
        check("R7 entered", 32'(id_mode), 32'd1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 prot after reset", 32'(prot_on), 32'd1);
        check("R1 id after reset", 32'(id_mode), 32'd0);
        check("R1 permit after reset", 32'(wr_permit), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule